// File: doc/BRIEF.md
# Receive Frame Prefix Padding Inserter

This stage sits in a byte-wide receive path between the MAC receive logic and the buffer writer. At the start of each frame it inserts a programmable run of padding bytes. With the right length, the IP header then starts on a 32-bit boundary in the receive buffer. When timestamping is active, the first eight padding bytes carry a 64-bit receive timestamp, most significant byte first. The stage also raises a one-cycle strobe on the output byte that is the first destination-address byte.

Each input frame is laid out as follows: an optional receive control block of `CB_BYTES` bytes, then an optional preamble of `PRE_BYTES` bytes, then an optional shim header of `2*cfg_l2_off` bytes, then the layer-2 header. Padding always goes directly after the control block. With no control block, it goes ahead of the first frame byte. In both cases it therefore lands before the preamble when a preamble is present, and before the layer-2 header when there is none.

Input and output are valid/ready streams. A byte moves on a cycle where valid and ready are both high. The sender must hold valid and its data until the byte is taken. The stage spends one cycle in its idle state capturing the configuration when it sees a start-of-frame byte, and it does not accept that byte in that cycle. While padding is being emitted, `in_ready` is low. Elsewhere inside a frame, `in_ready` follows `out_ready`, so a stall at the output halts input acceptance without losing or duplicating a byte. Configuration may change only between frames.

Top module: `rxpad_inserter`

## Requirements
- R1: After reset, `out_valid`, `out_sof` and `in_ready` are low, and `in_ready` stays low while no frame is open.
- R2: With timestamping inactive and a padding length N from 1 to 31, exactly N zero bytes are emitted ahead of the frame bytes, and every frame byte follows unchanged.
- R3: A padding length of 0 emits the frame bytes unchanged, with no extra bytes.
- R4: With `cfg_ts_en` and `timer_on` both high, the effective padding length is max(N, 8). Padding byte k, for k from 0 to 7, is bits [63-8k:56-8k] of the captured timestamp. Any padding byte beyond the eighth is zero.
- R5: When `timer_on` is low, timestamping is inactive even if `cfg_ts_en` is high: the padding is N zero bytes.
- R6: When `cfg_cb_present` is high, the first `CB_BYTES` frame bytes are output first, and the padding follows them.
- R7: `cfg_pre_present` does not move the padding. It only shifts the destination-address position by `PRE_BYTES`.
- R8: `out_da_start` is high on exactly one output byte per frame: the byte at input index `(cb?CB_BYTES:0)+(pre?PRE_BYTES:0)+2*cfg_l2_off`, counted from 0 at the first frame byte. If the frame is shorter than that, no output byte carries the strobe.
- R9: The configuration fields and `ts_value` are captured when a start-of-frame byte is seen in the idle state. Changes to them during the frame have no effect on that frame.
- R10: While `out_valid` is high and `out_ready` is low, the output byte and its flags are held. Every frame byte appears exactly once, in order.
- R11: `out_sof` marks the first output byte of a frame (a control-block byte or a padding byte). `out_eof` marks only the last frame byte.
- R12: With padding length 2, no control block and timestamping inactive, the byte that follows a 14-byte Ethernet header sits at output offset 16.
- R13: `in_ready` is low on every cycle in which a padding byte is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| cfg_pad_len | input | PAD_W | Programmed padding length, 0 to 31 |
| cfg_ts_en | input | 1 | Request a timestamp inside the padding |
| timer_on | input | 1 | Status of the timestamp timer; low disables timestamping |
| cfg_cb_present | input | 1 | Frame starts with a control block of CB_BYTES bytes |
| cfg_pre_present | input | 1 | Frame carries a PRE_BYTES-byte preamble |
| cfg_l2_off | input | L2_W | Shim length in 2-byte units before the destination address |
| ts_value | input | TS_W | Current receive timestamp |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_da_start | output | 1 | Output byte is the first destination-address byte |

## Verification
The bench builds the block with its defaults: an 8-byte control block, an 8-byte preamble, a 5-bit padding length, a 7-bit shim offset and a 64-bit timestamp. With these values the full padding range up to 31 is reachable, as are padding lengths above the 8-byte timestamp minimum. The destination-address position can be placed inside a frame or past its end, across all four combinations of the control-block and preamble flags. Random output back-pressure and input gaps run throughout. After each first byte is accepted, the configuration and timestamp inputs are scrambled, which exercises the capture rule.

// File: rtl/rxpad_pkg.sv
package rxpad_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEAD,
    ST_PAD,
    ST_BODY
  } rxpad_state_e;
endpackage

// File: rtl/rxpad_cfg_capture.sv
module rxpad_cfg_capture #(
  parameter int CB_BYTES  = 8,
  parameter int PRE_BYTES = 8,
  parameter int PAD_W     = 5,
  parameter int L2_W      = 7,
  parameter int TS_W      = 64,
  parameter int IDXW      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [PAD_W-1:0] cfg_pad_len,
  input  logic             cfg_ts_en,
  input  logic             timer_on,
  input  logic             cfg_cb_present,
  input  logic             cfg_pre_present,
  input  logic [L2_W-1:0]  cfg_l2_off,
  input  logic [TS_W-1:0]  ts_value,
  output logic             pad_live_nz,
  output logic [PAD_W-1:0] pad_q,
  output logic             ts_on_q,
  output logic             cb_q,
  output logic [IDXW-1:0]  da_idx_q,
  output logic [TS_W-1:0]  ts_q
);
  localparam int NB = TS_W / 8;

  logic             ts_live;
  logic [PAD_W-1:0] pad_live;
  logic [IDXW-1:0]  da_live;

  always_comb begin
    ts_live  = cfg_ts_en & timer_on;
    pad_live = (ts_live && (cfg_pad_len < PAD_W'(NB))) ? PAD_W'(NB) : cfg_pad_len;
    da_live  = (cfg_cb_present ? IDXW'(CB_BYTES) : '0)
             + (cfg_pre_present ? IDXW'(PRE_BYTES) : '0)
             + IDXW'({cfg_l2_off, 1'b0});
  end

  assign pad_live_nz = (pad_live != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_q    <= '0;
      ts_on_q  <= 1'b0;
      cb_q     <= 1'b0;
      da_idx_q <= '0;
      ts_q     <= '0;
    end else if (capture) begin
      pad_q    <= pad_live;
      ts_on_q  <= ts_live;
      cb_q     <= cfg_cb_present;
      da_idx_q <= da_live;
      ts_q     <= ts_value;
    end
  end
endmodule

// File: rtl/rxpad_pad_gen.sv
module rxpad_pad_gen #(
  parameter int PAD_W = 5,
  parameter int TS_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [PAD_W-1:0] pad_len,
  input  logic             ts_on,
  input  logic [TS_W-1:0]  ts,
  output logic [7:0]       pad_byte,
  output logic             pad_last
);
  localparam int NB   = TS_W / 8;
  localparam int SELW = (NB > 1) ? $clog2(NB) : 1;

  logic [PAD_W-1:0] cnt;
  logic [7:0]       ts_bytes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_tsb
    assign ts_bytes[g] = ts[TS_W-1-8*g -: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  always_comb begin
    pad_byte = 8'h00;
    if (ts_on && (cnt < PAD_W'(NB))) pad_byte = ts_bytes[cnt[SELW-1:0]];
    pad_last = (cnt == pad_len - 1'b1);
  end
endmodule

// File: rtl/rxpad_idx_ctr.sv
module rxpad_idx_ctr #(
  parameter int IDXW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            inc,
  output logic [IDXW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     idx <= '0;
    else if (clear)                 idx <= '0;
    else if (inc && (idx != '1))    idx <= idx + 1'b1;
  end
endmodule

// File: rtl/rxpad_inserter.sv
module rxpad_inserter #(
  parameter int CB_BYTES  = 8,
  parameter int PRE_BYTES = 8,
  parameter int PAD_W     = 5,
  parameter int L2_W      = 7,
  parameter int TS_W      = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [PAD_W-1:0] cfg_pad_len,
  input  logic             cfg_ts_en,
  input  logic             timer_on,
  input  logic             cfg_cb_present,
  input  logic             cfg_pre_present,
  input  logic [L2_W-1:0]  cfg_l2_off,
  input  logic [TS_W-1:0]  ts_value,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_da_start
);
  import rxpad_pkg::*;

  localparam int DA_MAX = CB_BYTES + PRE_BYTES + 2 * ((1 << L2_W) - 1);
  localparam int IDXW   = $clog2(DA_MAX + 2);
  localparam int CBW    = $clog2(CB_BYTES + 1);

  rxpad_state_e     st, st_nx;
  logic             capture, pass, xfer, first_q, pad_active;
  logic             pad_live_nz, ts_on_q, cb_q, pad_last;
  logic [PAD_W-1:0] pad_q;
  logic [IDXW-1:0]  da_idx_q, idx;
  logic [TS_W-1:0]  ts_q;
  logic [7:0]       pad_byte;
  logic [CBW-1:0]   cb_cnt;

  rxpad_cfg_capture #(
    .CB_BYTES(CB_BYTES), .PRE_BYTES(PRE_BYTES), .PAD_W(PAD_W),
    .L2_W(L2_W), .TS_W(TS_W), .IDXW(IDXW)
  ) u_cfg (
    .clk, .rst_n, .capture,
    .cfg_pad_len, .cfg_ts_en, .timer_on, .cfg_cb_present,
    .cfg_pre_present, .cfg_l2_off, .ts_value,
    .pad_live_nz, .pad_q, .ts_on_q, .cb_q, .da_idx_q, .ts_q
  );

  rxpad_pad_gen #(.PAD_W(PAD_W), .TS_W(TS_W)) u_pad (
    .clk, .rst_n, .start(capture), .step(pad_active & xfer),
    .pad_len(pad_q), .ts_on(ts_on_q), .ts(ts_q),
    .pad_byte, .pad_last
  );

  rxpad_idx_ctr #(.IDXW(IDXW)) u_idx (
    .clk, .rst_n, .clear(capture), .inc(in_valid & in_ready), .idx
  );

  always_comb begin
    capture    = (st == ST_IDLE) && in_valid && in_sof;
    pass       = (st == ST_HEAD) || (st == ST_BODY);
    pad_active = (st == ST_PAD);
    out_valid  = pad_active | (pass & in_valid);
    out_data   = pad_active ? pad_byte : in_data;
    in_ready   = pass & out_ready;
    xfer       = out_valid & out_ready;
    out_sof    = first_q & out_valid;
    out_eof    = pass & in_valid & in_eof;
    out_da_start = pass & in_valid & (idx == da_idx_q);
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:
        if (capture)
          st_nx = cfg_cb_present ? ST_HEAD : (pad_live_nz ? ST_PAD : ST_BODY);
      ST_HEAD:
        if (xfer && in_eof)
          st_nx = ST_IDLE;
        else if (xfer && (cb_cnt == CBW'(CB_BYTES - 1)))
          st_nx = (pad_q != '0) ? ST_PAD : ST_BODY;
      ST_PAD:
        if (xfer && pad_last) st_nx = ST_BODY;
      ST_BODY:
        if (xfer && in_eof) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      first_q <= 1'b0;
      cb_cnt  <= '0;
    end else begin
      st <= st_nx;
      if (capture)   first_q <= 1'b1;
      else if (xfer) first_q <= 1'b0;
      if (capture)                       cb_cnt <= '0;
      else if (xfer && (st == ST_HEAD))  cb_cnt <= cb_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxpad_checker.sv
module rxpad_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       out_da_start,
  input logic       in_ready,
  input logic       pad_active
);
  logic da_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                                         da_seen <= 1'b0;
    else if (out_valid && out_ready && out_eof)         da_seen <= 1'b0;
    else if (out_valid && out_ready && out_da_start)    da_seen <= 1'b1;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)
                                   && $stable(out_eof) && $stable(out_da_start)));

  // R13
  pad_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_active |-> !in_ready);

  // R11
  eof_not_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> !pad_active);

  // R11
  sof_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_sof) |=> !out_sof);

  // R8
  da_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_da_start) |-> !da_seen);
endmodule

bind rxpad_inserter rxpad_checker u_rxpad_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
  .out_da_start(out_da_start), .in_ready(in_ready), .pad_active(pad_active)
);

// File: tb/tb_rxpad_inserter.sv
module tb_rxpad_inserter;
  localparam int CB = 8, PRE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 0, in_sof = 0, in_eof = 0, out_ready = 1;
  logic [7:0]  in_data = 0;
  logic [4:0]  d_pad = 0;
  logic        d_ts = 0, d_tmr = 0, d_cb = 0, d_pre = 0;
  logic [6:0]  d_l2 = 0;
  logic [63:0] d_tsv = 0;
  logic        in_ready, out_valid, out_sof, out_eof, out_da;
  logic [7:0]  out_data;

  rxpad_inserter dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sof, .in_eof,
    .cfg_pad_len(d_pad), .cfg_ts_en(d_ts), .timer_on(d_tmr),
    .cfg_cb_present(d_cb), .cfg_pre_present(d_pre), .cfg_l2_off(d_l2),
    .ts_value(d_tsv), .out_valid, .out_ready, .out_data, .out_sof,
    .out_eof, .out_da_start(out_da)
  );

  int n_chk = 0, n_bad = 0;
  logic [4:0]  c_pad; logic c_ts, c_tmr, c_cb, c_pre; logic [6:0] c_l2; logic [63:0] c_tsv;
  logic [7:0]  fr [256]; int flen;
  logic [7:0]  ex_d [256]; logic ex_s [256], ex_e [256], ex_a [256]; int ex_n;
  logic [7:0]  mo_d [256]; logic mo_s [256], mo_e [256], mo_a [256];
  int mo_n = 0; logic mo_done = 0; logic bp_on = 0, gap_on = 0;

  function automatic int eff_pad();
    if (c_ts && c_tmr && c_pad < 8) return 8;
    return int'(c_pad);
  endfunction

  function automatic logic [7:0] pad_val(int k);
    if (c_ts && c_tmr && k < 8) return c_tsv[63-8*k -: 8];
    return 8'h00;
  endfunction

  task automatic build_expected();
    int p = eff_pad(); int cbn = c_cb ? CB : 0;
    int da = cbn + (c_pre ? PRE : 0) + 2 * int'(c_l2);
    ex_n = 0;
    for (int i = 0; i < flen; i++) begin
      if (i == cbn)
        for (int k = 0; k < p; k++) begin
          ex_d[ex_n] = pad_val(k); ex_s[ex_n] = 0; ex_e[ex_n] = 0; ex_a[ex_n] = 0; ex_n++;
        end
      ex_d[ex_n] = fr[i]; ex_s[ex_n] = 0; ex_e[ex_n] = (i == flen-1);
      ex_a[ex_n] = (i == da); ex_n++;
    end
    ex_s[0] = 1;
  endtask

  always @(negedge clk) out_ready = bp_on ? ($urandom % 10 < 7) : 1'b1;

  always @(negedge clk) begin
    #8;
    if (rst_n && out_valid && out_ready && mo_n < 256) begin
      mo_d[mo_n] = out_data; mo_s[mo_n] = out_sof; mo_e[mo_n] = out_eof; mo_a[mo_n] = out_da;
      mo_n++;
      if (out_eof) mo_done = 1;
    end
  end

  task automatic check(logic ok, string req, string what);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s %s", req, what); end
  endtask

  task automatic run_frame(string req);
    build_expected();
    mo_n = 0; mo_done = 0;
    @(negedge clk);
    d_pad = c_pad; d_ts = c_ts; d_tmr = c_tmr; d_cb = c_cb; d_pre = c_pre; d_l2 = c_l2; d_tsv = c_tsv;
    for (int i = 0; i < flen; i++) begin
      if (gap_on) while ($urandom % 4 == 0) begin in_valid = 0; @(negedge clk); end
      in_valid = 1; in_data = fr[i]; in_sof = (i == 0); in_eof = (i == flen-1);
      forever begin
        #8;
        if (in_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0;
      if (i == 0) begin  // R9: scramble after capture
        d_pad = 5'($urandom); d_ts = ~c_ts; d_tmr = ~c_tmr; d_cb = ~c_cb; d_pre = ~c_pre;
        d_l2 = 7'($urandom); d_tsv = {$urandom, $urandom};
      end
    end
    wait (mo_done);
    check(mo_n == ex_n, req, $sformatf("length actual %0d expected %0d", mo_n, ex_n));
    for (int i = 0; i < ex_n && i < mo_n; i++)
      check({mo_d[i], mo_s[i], mo_e[i], mo_a[i]} == {ex_d[i], ex_s[i], ex_e[i], ex_a[i]}, req,
        $sformatf("byte %0d actual d=%h s%b e%b da%b expected d=%h s%b e%b da%b", i,
          mo_d[i], mo_s[i], mo_e[i], mo_a[i], ex_d[i], ex_s[i], ex_e[i], ex_a[i]));
  endtask

  task automatic setup(int pad, bit ts, bit tmr, bit cb, bit pre, int l2, int len);
    c_pad = 5'(pad); c_ts = ts; c_tmr = tmr; c_cb = cb; c_pre = pre; c_l2 = 7'(l2);
    c_tsv = {$urandom, $urandom}; flen = len;
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    #8;
    check(!out_valid && !in_ready && !out_sof, "R1",
          $sformatf("reset actual v%b r%b s%b expected 000", out_valid, in_ready, out_sof));
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    in_valid = 0; #8;
    check(!in_ready, "R1", $sformatf("idle in_ready actual %b expected 0", in_ready));

    setup(0, 0, 1, 0, 0, 0, 20);  run_frame("R3");
    setup(5, 0, 1, 0, 0, 0, 24);  run_frame("R2");
    setup(2, 0, 1, 0, 0, 0, 60);  run_frame("R12");
    check(mo_d[16] == fr[14], "R12", $sformatf("out[16] actual %h expected %h", mo_d[16], fr[14]));
    setup(3, 1, 1, 0, 0, 0, 30);  run_frame("R4");
    setup(12, 1, 1, 0, 0, 2, 30); run_frame("R4");
    setup(3, 1, 0, 0, 0, 0, 30);  run_frame("R5");
    setup(4, 0, 1, 1, 0, 0, 30);  run_frame("R6");
    setup(6, 0, 1, 1, 1, 3, 40);  run_frame("R7");
    setup(1, 0, 1, 0, 1, 0, 20);  run_frame("R8");
    setup(0, 0, 1, 0, 0, 60, 20); run_frame("R8");
    setup(31, 1, 1, 1, 0, 1, 25); run_frame("R2");
    setup(0, 0, 1, 0, 0, 0, 1);   run_frame("R11");

    bp_on = 1; gap_on = 1;
    for (int t = 0; t < 60; t++) begin
      bit cb = 1'($urandom);
      setup($urandom % 32, 1'($urandom), 1'($urandom), cb, 1'($urandom), $urandom % 24,
            (cb ? CB : 0) + 1 + $urandom % 60);
      run_frame("R10");
    end
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule